// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 memory link. It takes the device from reset to the point where it can accept normal commands. It drives the device reset line, the clock enable, the on-die termination control, the four command strobes (chip select, row strobe, column strobe, write enable), the 3-bit bank address and the row/column address bus. Every wait interval is a cycle count. By default each count is derived from a clock-period parameter, and any of them can be overridden.

On a synchronous restart request the block captures the four mode-register words from its input ports. It then:

1. holds the device in reset;
2. releases reset and waits for the power-up interval with clock enable low;
3. waits a further clock-stable interval;
4. raises clock enable together with a NOP;
5. waits the exit-reset interval;
6. writes the mode registers in the order 2, 3, 1, 0, a fixed spacing apart;
7. waits the mode-update interval and issues a long ZQ calibration;
8. waits the longer of the calibration and DLL-lock intervals, then holds `initDone` high.

One shared down-counter times every interval. It is reloaded whenever the sequencer changes step.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it was sampled high, the outputs are: `memRstN`=0, `memClkEn`=0, `initDone`=0, command {chip select, row, column, write} = 1111 (deselect), bank 0, address 0.
- R2: After the last clock edge that samples `rst` high, `memRstN` stays low for RST_HOLD_CYC+1 sampled cycles and then stays high.
- R3: `memClkEn` stays low for PWRUP_CYC+CLK_STABLE_CYC cycles after `memRstN` rises. It then rises in the same cycle as a NOP (command 0111) and stays high.
- R4: The first mode-register write comes exactly XPR_CYC cycles after the NOP. Every cycle in between is a deselect.
- R5: Mode-register writes use command 0000, in the order bank 010, 011, 001, 000, each exactly MRD_CYC cycles after the previous one. Deselect fills the gaps.
- R6: The address of each mode-register write is the word captured from the matching `modeRegN` port on the last edge with `rst` high. Register 1 has bit 0 forced to 0 (DLL enabled) and register 0 has bit 8 forced to 1 (DLL reset). Changes to the ports after reset is released have no effect.
- R7: Exactly MOD_CYC cycles after the register-0 write, the block issues a long ZQ calibration: command 0110, address bit 10 high, all other address bits 0, bank 0.
- R8: `initDone` rises exactly max(ZQINIT_CYC, DLLK_CYC) cycles after the calibration command and stays high until the next `rst`. Every other cycle up to then is a deselect.
- R9: `memTermEn` is held at a static level throughout: 0 when TERM_NOM_ON is 1, otherwise TERM_LEVEL.
- R10: A `rst` request at any point in the sequence returns the outputs to the R1 state. The whole sequence then restarts from the reset-low step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous restart request, active high |
| modeReg0 | input | ADDR_W | Mode register 0 word |
| modeReg1 | input | ADDR_W | Mode register 1 word |
| modeReg2 | input | ADDR_W | Mode register 2 word |
| modeReg3 | input | ADDR_W | Mode register 3 word |
| memRstN | output | 1 | Device reset, active low |
| memClkEn | output | 1 | Device clock enable |
| memTermEn | output | 1 | Device termination control, static |
| memChipSelN | output | 1 | Chip select, active low |
| memRowStrN | output | 1 | Row strobe, active low |
| memColStrN | output | 1 | Column strobe, active low |
| memWrEnN | output | 1 | Write enable, active low |
| memBank | output | 3 | Bank address |
| memAddr | output | ADDR_W | Address bus |
| initDone | output | 1 | Sequence complete |

## Verification
All outputs are registered from the sequencer state. Each pin therefore shows the step that was current one edge earlier: a step that begins at edge k appears on the pins after edge k+1. The bench model follows a timeline of step lengths, counted in edges since the last edge that sampled `rst` high. At each falling edge it predicts every pin from the step that was current one edge before, and compares all of them. The gaps between commands (exit-reset, register spacing, mode update, calibration wait) therefore show as exact cycle distances rather than lower bounds. A restart in the middle of the power-up wait is checked the same way, from the restart edge onward.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  // Command encoding on {chip select, row strobe, column strobe, write enable}
  typedef enum logic [3:0] {
    CMD_DES  = 4'b1111,
    CMD_NOP  = 4'b0111,
    CMD_MRS  = 4'b0000,
    CMD_ZQCL = 4'b0110
  } cmd_e;

  // Which interval the shared counter is loaded with
  typedef enum logic [2:0] {
    LD_ONE, LD_RST, LD_PWR, LD_CKS, LD_XPR, LD_MRD, LD_MOD, LD_ZQ
  } ld_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       load;
    ld_e        ldSel;
    logic       rstRelease;
    logic       clkEnOn;
    cmd_e       cmd;
    logic [1:0] mrIdx;
    logic       done;
  } strobe_t;

endpackage

// File: rtl/ddr3_init_ctrl.sv
module ddr3_init_ctrl
  import ddr3_init_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cntZero,
  output strobe_t strb
);

  typedef enum logic [3:0] {
    S_RST, S_PWR, S_CKS, S_NOP, S_XPR,
    S_MR2, S_W2, S_MR3, S_W3, S_MR1, S_W1, S_MR0,
    S_MOD, S_ZQ, S_ZQW, S_DONE
  } state_e;

  state_e state, nextState;

  function automatic ld_e ldFor(state_e s);
    case (s)
      S_RST:             ldFor = LD_RST;
      S_PWR:             ldFor = LD_PWR;
      S_CKS:             ldFor = LD_CKS;
      S_XPR:             ldFor = LD_XPR;
      S_W2, S_W3, S_W1:  ldFor = LD_MRD;
      S_MOD:             ldFor = LD_MOD;
      S_ZQW:             ldFor = LD_ZQ;
      default:           ldFor = LD_ONE;
    endcase
  endfunction

  always_comb begin
    if (rst)
      nextState = S_RST;
    else if (cntZero && state != S_DONE)
      nextState = state_e'(state + 4'd1);
    else
      nextState = state;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_RST;
    else     state <= nextState;
  end

  always_comb begin
    strb.load       = rst | cntZero;
    strb.ldSel      = ldFor(nextState);
    strb.rstRelease = (state != S_RST);
    strb.clkEnOn    = (state >= S_NOP);
    strb.done       = (state == S_DONE);
    strb.mrIdx      = 2'd0;
    case (state)
      S_NOP:   strb.cmd = CMD_NOP;
      S_MR2:   begin strb.cmd = CMD_MRS; strb.mrIdx = 2'd2; end
      S_MR3:   begin strb.cmd = CMD_MRS; strb.mrIdx = 2'd3; end
      S_MR1:   begin strb.cmd = CMD_MRS; strb.mrIdx = 2'd1; end
      S_MR0:   begin strb.cmd = CMD_MRS; strb.mrIdx = 2'd0; end
      S_ZQ:    strb.cmd = CMD_ZQCL;
      default: strb.cmd = CMD_DES;
    endcase
  end

  // R2: a step is left only when the shared counter has run out
  a_r2_hold_until_zero: assert property (@(posedge clk) disable iff (rst)
    !cntZero |=> state == $past(state));

  // R10: a restart request always lands in the reset step
  a_r10_restart: assert property (@(posedge clk)
    rst |=> state == S_RST);

endmodule

// File: rtl/ddr3_init_dp.sv
module ddr3_init_dp
  import ddr3_init_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int RST_HOLD_CYC   = 13,
  parameter int PWRUP_CYC      = 62500,
  parameter int CLK_STABLE_CYC = 5,
  parameter int XPR_CYC        = 34,
  parameter int MRD_CYC        = 4,
  parameter int MOD_CYC        = 12,
  parameter int ZQINIT_CYC     = 512,
  parameter int DLLK_CYC       = 512,
  parameter bit TERM_NOM_ON    = 1'b1,
  parameter bit TERM_LEVEL     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] modeReg0,
  input  logic [ADDR_W-1:0] modeReg1,
  input  logic [ADDR_W-1:0] modeReg2,
  input  logic [ADDR_W-1:0] modeReg3,
  output logic              cntZero,
  output logic              memRstN,
  output logic              memClkEn,
  output logic              memTermEn,
  output logic [3:0]        memCmd,
  output logic [2:0]        memBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initDone
);

  localparam int  ZQ_CYC  = (ZQINIT_CYC > DLLK_CYC) ? ZQINIT_CYC : DLLK_CYC;
  localparam int  MAX_A   = (RST_HOLD_CYC > PWRUP_CYC) ? RST_HOLD_CYC : PWRUP_CYC;
  localparam int  MAX_B   = (ZQ_CYC > XPR_CYC) ? ZQ_CYC : XPR_CYC;
  localparam int  MAX_C   = (MOD_CYC > CLK_STABLE_CYC) ? MOD_CYC : CLK_STABLE_CYC;
  localparam int  MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int  MAX_LEN = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int  CNT_W   = $clog2(MAX_LEN + 1);
  localparam bit  TERM_VAL = TERM_NOM_ON ? 1'b0 : TERM_LEVEL;
  localparam int  ZQ_BIT   = 10;
  localparam int  DLLRST_BIT = 8;

  logic [CNT_W-1:0]  cnt, ldVal;
  logic [ADDR_W-1:0] mrLat [4];
  logic [ADDR_W-1:0] addrNext;
  logic [2:0]        bankNext;

  // Interval selection for the shared counter (command steps last one cycle)
  always_comb begin
    case (strb.ldSel)
      LD_RST:  ldVal = CNT_W'(RST_HOLD_CYC - 1);
      LD_PWR:  ldVal = CNT_W'(PWRUP_CYC - 1);
      LD_CKS:  ldVal = CNT_W'(CLK_STABLE_CYC - 1);
      LD_XPR:  ldVal = CNT_W'(XPR_CYC - 2);
      LD_MRD:  ldVal = CNT_W'(MRD_CYC - 2);
      LD_MOD:  ldVal = CNT_W'(MOD_CYC - 2);
      LD_ZQ:   ldVal = CNT_W'(ZQ_CYC - 2);
      default: ldVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.load) cnt <= ldVal;
    else           cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  // Mode words are captured while a restart is requested
  always_ff @(posedge clk) begin
    if (rst) begin
      mrLat[0] <= modeReg0;
      mrLat[1] <= modeReg1;
      mrLat[2] <= modeReg2;
      mrLat[3] <= modeReg3;
    end
  end

  always_comb begin
    addrNext = '0;
    bankNext = 3'b000;
    case (strb.cmd)
      CMD_MRS: begin
        bankNext = {1'b0, strb.mrIdx};
        addrNext = mrLat[strb.mrIdx];
        if (strb.mrIdx == 2'd1) addrNext[0] = 1'b0;
        if (strb.mrIdx == 2'd0) addrNext[DLLRST_BIT] = 1'b1;
      end
      CMD_ZQCL: addrNext[ZQ_BIT] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memRstN   <= 1'b0;
      memClkEn  <= 1'b0;
      memTermEn <= TERM_VAL;
      memCmd    <= CMD_DES;
      memBank   <= 3'b000;
      memAddr   <= '0;
      initDone  <= 1'b0;
    end else begin
      memRstN   <= strb.rstRelease;
      memClkEn  <= strb.clkEnOn;
      memTermEn <= TERM_VAL;
      memCmd    <= strb.cmd;
      memBank   <= bankNext;
      memAddr   <= addrNext;
      initDone  <= strb.done;
    end
  end

  // Spacing tracker for the command-gap assertions
  logic [15:0] gapCnt;
  logic        prevMrs;
  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt  <= '0;
      prevMrs <= 1'b0;
    end else if (memCmd[3] == 1'b0) begin
      gapCnt  <= 16'd1;
      prevMrs <= (memCmd == CMD_MRS);
    end else if (gapCnt != 16'hFFFF) begin
      gapCnt  <= gapCnt + 16'd1;
    end
  end

  // R3: the clock enable never rises while the device is held in reset
  a_r3_clken_after_reset: assert property (@(posedge clk) disable iff (rst)
    !memRstN |-> !memClkEn);

  // R4: no command is selected while the clock enable is low
  a_r4_cmd_needs_clken: assert property (@(posedge clk) disable iff (rst)
    !memCmd[3] |-> memClkEn);

  // R5: back-to-back mode-register writes keep the minimum spacing
  a_r5_mrd_spacing: assert property (@(posedge clk) disable iff (rst)
    (memCmd == CMD_MRS && prevMrs) |-> int'(gapCnt) >= MRD_CYC);

  // R7: calibration follows a mode-register write after the update interval
  a_r7_mod_spacing: assert property (@(posedge clk) disable iff (rst)
    (memCmd == CMD_ZQCL) |-> (prevMrs && int'(gapCnt) >= MOD_CYC));

  // R8: once complete, the sequence stays complete
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

  // R9: the termination control never moves
  a_r9_term_static: assert property (@(posedge clk) disable iff (rst)
    $stable(memTermEn));

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int CLK_PS         = 8000,
  parameter int RST_HOLD_CYC   = (100000 + CLK_PS - 1) / CLK_PS,
  parameter int PWRUP_CYC      = (500000000 + CLK_PS - 1) / CLK_PS,
  parameter int CLK_STABLE_CYC = ((10000 + CLK_PS - 1) / CLK_PS > 5) ?
                                 (10000 + CLK_PS - 1) / CLK_PS : 5,
  parameter int XPR_CYC        = 34,
  parameter int MRD_CYC        = 4,
  parameter int MOD_CYC        = 12,
  parameter int ZQINIT_CYC     = 512,
  parameter int DLLK_CYC       = 512,
  parameter bit TERM_NOM_ON    = 1'b1,
  parameter bit TERM_LEVEL     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] modeReg0,
  input  logic [ADDR_W-1:0] modeReg1,
  input  logic [ADDR_W-1:0] modeReg2,
  input  logic [ADDR_W-1:0] modeReg3,
  output logic              memRstN,
  output logic              memClkEn,
  output logic              memTermEn,
  output logic              memChipSelN,
  output logic              memRowStrN,
  output logic              memColStrN,
  output logic              memWrEnN,
  output logic [2:0]        memBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initDone
);

  strobe_t    strb;
  logic       cntZero;
  logic [3:0] memCmd;

  ddr3_init_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .cntZero (cntZero),
    .strb    (strb)
  );

  ddr3_init_dp #(
    .ADDR_W         (ADDR_W),
    .RST_HOLD_CYC   (RST_HOLD_CYC),
    .PWRUP_CYC      (PWRUP_CYC),
    .CLK_STABLE_CYC (CLK_STABLE_CYC),
    .XPR_CYC        (XPR_CYC),
    .MRD_CYC        (MRD_CYC),
    .MOD_CYC        (MOD_CYC),
    .ZQINIT_CYC     (ZQINIT_CYC),
    .DLLK_CYC       (DLLK_CYC),
    .TERM_NOM_ON    (TERM_NOM_ON),
    .TERM_LEVEL     (TERM_LEVEL)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .modeReg0  (modeReg0),
    .modeReg1  (modeReg1),
    .modeReg2  (modeReg2),
    .modeReg3  (modeReg3),
    .cntZero   (cntZero),
    .memRstN   (memRstN),
    .memClkEn  (memClkEn),
    .memTermEn (memTermEn),
    .memCmd    (memCmd),
    .memBank   (memBank),
    .memAddr   (memAddr),
    .initDone  (initDone)
  );

  assign {memChipSelN, memRowStrN, memColStrN, memWrEnN} = memCmd;

endmodule

// File: tb/ddr3_init_seq_tb_top.sv
module ddr3_init_seq_tb_top;

  localparam int T_RST = 13;
  localparam int T_PWR = 200;
  localparam int T_CKS = 5;
  localparam int T_XPR = 30;
  localparam int T_MRD = 4;
  localparam int T_MOD = 12;
  localparam int T_ZQI = 64;
  localparam int T_DLK = 80;
  localparam int T_ZQ  = (T_ZQI > T_DLK) ? T_ZQI : T_DLK;
  localparam int TOTAL = T_RST + T_PWR + T_CKS + T_XPR + 3 * T_MRD + T_MOD + T_ZQ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] mr0, mr1, mr2, mr3;
  logic memRstN, memClkEn, memTermEn, csN, rasN, casN, weN, initDone;
  logic [2:0] memBank;
  logic [15:0] memAddr;

  always #4 clk = ~clk;

  ddr3_init_seq #(
    .ADDR_W(16), .RST_HOLD_CYC(T_RST), .PWRUP_CYC(T_PWR), .CLK_STABLE_CYC(T_CKS),
    .XPR_CYC(T_XPR), .MRD_CYC(T_MRD), .MOD_CYC(T_MOD), .ZQINIT_CYC(T_ZQI),
    .DLLK_CYC(T_DLK), .TERM_NOM_ON(1'b1), .TERM_LEVEL(1'b1)
  ) dut_i (
    .clk(clk), .rst(rst), .modeReg0(mr0), .modeReg1(mr1), .modeReg2(mr2), .modeReg3(mr3),
    .memRstN(memRstN), .memClkEn(memClkEn), .memTermEn(memTermEn),
    .memChipSelN(csN), .memRowStrN(rasN), .memColStrN(casN), .memWrEnN(weN),
    .memBank(memBank), .memAddr(memAddr), .initDone(initDone)
  );

  int compared = 0;
  int mismatched = 0;
  int m = 0;
  int cycles = 0;
  bit started = 0;
  bit rstSeen = 1'b1;
  bit finished = 0;
  string rstTag = "R1";
  logic [15:0] mrExp [4];
  int segLen [16];

  initial begin
    segLen[0] = T_RST;     segLen[1] = T_PWR;     segLen[2] = T_CKS;
    segLen[3] = 1;         segLen[4] = T_XPR - 1; segLen[5] = 1;
    segLen[6] = T_MRD - 1; segLen[7] = 1;         segLen[8] = T_MRD - 1;
    segLen[9] = 1;         segLen[10] = T_MRD - 1; segLen[11] = 1;
    segLen[12] = T_MOD - 1; segLen[13] = 1;       segLen[14] = T_ZQ - 1;
    segLen[15] = 0;
  end

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at step %0d: actual %h expected %h", tag, nm, m, act, exp);
    end
  endtask

  function automatic int segAt(int j);
    int r = j;
    for (int i = 0; i < 15; i++) begin
      if (r < segLen[i]) return i;
      r -= segLen[i];
    end
    return 15;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    rstSeen <= rst;
    if (rst) begin
      mrExp[0] <= mr0; mrExp[1] <= mr1; mrExp[2] <= mr2; mrExp[3] <= mr3;
    end
  end

  always @(negedge clk) begin
    logic eRn, eCke, eDone;
    logic [3:0] eCmd;
    logic [2:0] eBa;
    logic [15:0] eAddr;
    string tg, tgA;
    int s;
    if (started) begin
      if (rstSeen) begin
        m = 0;
        eRn = 0; eCke = 0; eCmd = 4'b1111; eBa = 0; eAddr = 0; eDone = 0;
        tg = rstTag; tgA = rstTag;
      end else begin
        m = m + 1;
        s = segAt(m - 1);
        eRn = (s != 0);
        eCke = (s >= 3);
        eDone = (s == 15);
        eBa = 0; eAddr = 0; eCmd = 4'b1111;
        case (s)
          0: tg = "R2";
          1, 2, 3: tg = "R3";
          4: tg = "R4";
          12, 13: tg = "R7";
          14, 15: tg = "R8";
          default: tg = "R5";
        endcase
        tgA = tg;
        case (s)
          3:  eCmd = 4'b0111;
          5:  begin eCmd = 4'b0000; eBa = 3'b010; eAddr = mrExp[2]; tgA = "R6"; end
          7:  begin eCmd = 4'b0000; eBa = 3'b011; eAddr = mrExp[3]; tgA = "R6"; end
          9:  begin eCmd = 4'b0000; eBa = 3'b001; eAddr = mrExp[1] & 16'hFFFE; tgA = "R6"; end
          11: begin eCmd = 4'b0000; eBa = 3'b000; eAddr = mrExp[0] | 16'h0100; tgA = "R6"; end
          13: begin eCmd = 4'b0110; eAddr = 16'h0400; end
          default: ;
        endcase
      end
      chk(tg, "reset_n", 32'(memRstN), 32'(eRn));
      chk(tg, "clk_en", 32'(memClkEn), 32'(eCke));
      chk(tg, "command", 32'({csN, rasN, casN, weN}), 32'(eCmd));
      chk(tg, "bank", 32'(memBank), 32'(eBa));
      chk(tgA, "address", 32'(memAddr), 32'(eAddr));
      chk(tg, "init_done", 32'(initDone), 32'(eDone));
      chk("R9", "term", 32'(memTermEn), 32'd0);
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // Run 1: R6 capture, then inputs changed after release
    mr0 = 16'h1234; mr1 = 16'h0045; mr2 = 16'h0018; mr3 = 16'h0004;
    rstTag = "R1";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    mr0 = 16'hFFFF; mr1 = 16'hFFFF; mr2 = 16'hFFFF; mr3 = 16'hFFFF;
    repeat (TOTAL + 20) @(posedge clk);
    // Run 2: new words, restarted in the middle of the power-up wait (R10)
    #1 rst = 1'b1;
    mr0 = 16'h0D70; mr1 = 16'h0006; mr2 = 16'h0208; mr3 = 16'h0000;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    repeat (T_RST + 100) @(posedge clk);
    #1 rst = 1'b1;
    rstTag = "R10";
    mr0 = 16'h0A5A; mr1 = 16'h0101; mr2 = 16'h0030; mr3 = 16'h0007;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    repeat (TOTAL + 20) @(posedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule